// File: doc/BRIEF.md
# Frame-Rate Speed-Mode Detector

This block watches an audio frame clock (one cycle per stereo sample) that arrives without any phase relation to the local reference clock. It measures how many reference cycles each frame period lasts and sorts that period into one of three speed classes: single, double or quad. The classes cover three separate rate bands with gaps between them. A period that falls in a gap, or above or below every band, is reported as unsupported. A new class reaches the output only after several frame periods in a row agree, so a jittery frame clock near a band edge cannot make the mode flicker.

A configuration bit can turn automatic detection off. Two select bits then set the mode directly, and the value that selects no mode is reported as unsupported. Measurement keeps running during manual control, so the measured class appears again as soon as automatic mode is restored. The chosen mode also drives two side outputs. One judges whether the master-clock to frame-clock ratio is legal in that mode, including the rule that the largest ratio needs the master-clock halving option. The other passes a de-emphasis request through only in single speed.

Top module: `smd_speed_detect`

## Requirements
- R1: After reset the mode output is 3 (unsupported), the supported flag is 0, the ratio flag is 0 and de-emphasis is off, even with a de-emphasis request present.
- R2: In automatic mode, a steady frame rate whose reference-cycle period P satisfies 4 kHz <= REF_HZ/P <= 50 kHz gives mode code 0 (single) and the supported flag set.
- R3: In automatic mode, a steady rate with 84 kHz <= REF_HZ/P <= 100 kHz gives mode code 1 (double).
- R4: In automatic mode, a steady rate with 170 kHz <= REF_HZ/P <= 200 kHz gives mode code 2 (quad).
- R5: In automatic mode, a rate in a gap or outside every band, or a frame clock that stops for longer than the slowest single-speed period, gives mode code 3 with the supported flag cleared.
- R6: The automatic mode changes only after 3 consecutive measured periods fall in the same class. Two such periods followed by a different one leave the mode unchanged.
- R7: With the auto-off bit set, select value 0, 1 or 2 gives mode code 0, 1 or 2 at once, and select value 3 gives mode code 3 (unsupported).
- R8: Measurement continues while the auto-off bit is set. Clearing it shows the class committed from the frame clock during the manual period.
- R9: The ratio flag is set only when the ratio input is legal for the current mode: 256, 384, 512, 768 or 1024 in single speed; 128, 192, 256, 384 or 512 in double speed; 128, 192 or 256 in quad speed. It is never set when the mode is unsupported.
- R10: The highest legal ratio of each mode (1024 single, 512 double, 256 quad) counts as legal only while the halving-enable input is 1. The other legal ratios do not depend on that input.
- R11: The de-emphasis output equals the de-emphasis request only when the mode is 0 (single). In every other mode it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, REF_HZ cycles per second |
| rst_n | input | 1 | Active-low asynchronous reset |
| fclk_i | input | 1 | Frame clock, asynchronous to clk |
| auto_off_i | input | 1 | 1 = manual mode selection, 0 = automatic detection |
| mc_i | input | 2 | Manual mode select: 0 single, 1 double, 2 quad, 3 unsupported |
| ratio_i | input | 11 | Master-clock to frame-clock ratio in use |
| div2_i | input | 1 | Master-clock halving enabled |
| deemph_req_i | input | 1 | De-emphasis request |
| mode_o | output | 2 | Speed mode: 0 single, 1 double, 2 quad, 3 unsupported |
| mode_ok_o | output | 1 | Mode is one of the three supported modes |
| ratio_ok_o | output | 1 | Ratio input is legal for the mode |
| deemph_on_o | output | 1 | Masked de-emphasis enable |

## Verification
An off-by-one in the cycle counter or in a window limit shows up as a wrong mode code at a band edge. It appears three frame periods after the edge period starts, so the period sweep steps across every edge of every band. A wrong run counter in the agreement filter shows as a mode change after only two agreeing periods, or as no change after the third. The bench places its checks between exactly those two frame edges. A wrong primed or timeout state shows when the frame clock stops: the unsupported code must appear within three timeout intervals.

// File: rtl/smd_pkg.sv
`timescale 1ns/1ps
package smd_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_NONE   = 2'd3
  } spd_e;

  // Smallest period count whose rate does not exceed f_hz.
  function automatic int min_count(input int ref_hz, input int f_hz);
    return (ref_hz + f_hz - 1) / f_hz;
  endfunction

  // Largest period count whose rate is not below f_hz.
  function automatic int max_count(input int ref_hz, input int f_hz);
    return ref_hz / f_hz;
  endfunction

  // Legal clock ratio per speed; the top entry needs the halving option.
  function automatic logic ratio_legal(input spd_e spd, input logic [10:0] r,
                                       input logic div2);
    logic ok;
    ok = 1'b0;
    case (spd)
      SPD_SINGLE: ok = (r == 11'd256) || (r == 11'd384) || (r == 11'd512) ||
                       (r == 11'd768) || ((r == 11'd1024) && div2);
      SPD_DOUBLE: ok = (r == 11'd128) || (r == 11'd192) || (r == 11'd256) ||
                       (r == 11'd384) || ((r == 11'd512) && div2);
      SPD_QUAD:   ok = (r == 11'd128) || (r == 11'd192) ||
                       ((r == 11'd256) && div2);
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/smd_frame_edge.sv
`timescale 1ns/1ps
module smd_frame_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fclk_async,
  output logic rise_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], fclk_async};
  end

  // Rising edge seen at the synchronised stage.
  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

endmodule

// File: rtl/smd_period_meter.sv
`timescale 1ns/1ps
module smd_period_meter
  import smd_pkg::*;
#(
  parameter int REF_HZ    = 50_000_000,
  parameter int S_MIN_HZ  = 4_000,
  parameter int S_MAX_HZ  = 50_000,
  parameter int D_MIN_HZ  = 84_000,
  parameter int D_MAX_HZ  = 100_000,
  parameter int Q_MIN_HZ  = 170_000,
  parameter int Q_MAX_HZ  = 200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic smp_vld_o,
  output spd_e smp_cls_o
);
  localparam int S_LO  = min_count(REF_HZ, S_MAX_HZ);
  localparam int S_HI  = max_count(REF_HZ, S_MIN_HZ);
  localparam int D_LO  = min_count(REF_HZ, D_MAX_HZ);
  localparam int D_HI  = max_count(REF_HZ, D_MIN_HZ);
  localparam int Q_LO  = min_count(REF_HZ, Q_MAX_HZ);
  localparam int Q_HI  = max_count(REF_HZ, Q_MIN_HZ);
  localparam int TMO   = S_HI + 1;
  localparam int CNT_W = $clog2(TMO + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;
  logic             tmo_hit;

  function automatic spd_e classify(input int n);
    if (n >= S_LO && n <= S_HI)      return SPD_SINGLE;
    else if (n >= D_LO && n <= D_HI) return SPD_DOUBLE;
    else if (n >= Q_LO && n <= Q_HI) return SPD_QUAD;
    else                             return SPD_NONE;
  endfunction

  assign tmo_hit = (cnt_q == CNT_W'(TMO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_W'(1);
      primed_q  <= 1'b0;
      smp_vld_o <= 1'b0;
      smp_cls_o <= SPD_NONE;
    end else begin
      smp_vld_o <= 1'b0;
      if (rise_i) begin
        cnt_q    <= CNT_W'(1);
        primed_q <= 1'b1;
        if (primed_q) begin
          smp_vld_o <= 1'b1;
          smp_cls_o <= classify(int'(cnt_q));
        end
      end else if (tmo_hit) begin
        cnt_q     <= CNT_W'(1);
        primed_q  <= 1'b0;
        smp_vld_o <= 1'b1;
        smp_cls_o <= SPD_NONE;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= CNT_W'(TMO)));  // R5

  AST_SAMPLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_vld_o) |-> ($past(rise_i) || $past(cnt_q) == CNT_W'(TMO)));  // R5

endmodule

// File: rtl/smd_run_filter.sv
`timescale 1ns/1ps
module smd_run_filter
  import smd_pkg::*;
#(
  parameter int STABLE_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld_i,
  input  spd_e smp_cls_i,
  output spd_e commit_o
);
  localparam int RUN_W = $clog2(STABLE_N + 1);

  spd_e             cand_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;

  always_comb begin
    if (smp_cls_i == cand_q)
      run_nxt = (run_q == RUN_W'(STABLE_N)) ? run_q : run_q + RUN_W'(1);
    else
      run_nxt = RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= SPD_NONE;
      run_q    <= '0;
      commit_o <= SPD_NONE;
    end else if (smp_vld_i) begin
      cand_q <= smp_cls_i;
      run_q  <= run_nxt;
      if (run_nxt == RUN_W'(STABLE_N)) commit_o <= smp_cls_i;
    end
  end

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(STABLE_N));  // R6

  AST_COMMIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(commit_o) |-> $past(smp_vld_i));  // R6

endmodule

// File: rtl/smd_speed_detect.sv
`timescale 1ns/1ps
module smd_speed_detect
  import smd_pkg::*;
#(
  parameter int REF_HZ      = 50_000_000,
  parameter int STABLE_N    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fclk_i,
  input  logic        auto_off_i,
  input  logic [1:0]  mc_i,
  input  logic [10:0] ratio_i,
  input  logic        div2_i,
  input  logic        deemph_req_i,
  output logic [1:0]  mode_o,
  output logic        mode_ok_o,
  output logic        ratio_ok_o,
  output logic        deemph_on_o
);
  logic rise;
  logic smp_vld;
  spd_e smp_cls;
  spd_e commit;
  spd_e mode_sel;

  smd_frame_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst_n(rst_n), .fclk_async(fclk_i), .rise_o(rise)
  );

  smd_period_meter #(.REF_HZ(REF_HZ)) meter_i (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .smp_vld_o(smp_vld), .smp_cls_o(smp_cls)
  );

  smd_run_filter #(.STABLE_N(STABLE_N)) filt_i (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .smp_cls_i(smp_cls),
    .commit_o(commit)
  );

  assign mode_sel    = auto_off_i ? spd_e'(mc_i) : commit;
  assign mode_o      = mode_sel;
  assign mode_ok_o   = (mode_sel != SPD_NONE);
  assign ratio_ok_o  = ratio_legal(mode_sel, ratio_i, div2_i);
  assign deemph_on_o = deemph_req_i & (mode_sel == SPD_SINGLE);

  AST_RATIO_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ok_o |-> mode_ok_o);  // R9

  AST_DEEMPH_SINGLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    deemph_on_o |-> (mode_o == 2'd0 && mode_ok_o));  // R11

  AST_AUTO_CHANGE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_off_i && $past(!auto_off_i) && mode_o != $past(mode_o)) |-> $past(smp_vld));  // R6

endmodule

// File: tb/smd_speed_detect_tb.sv
`timescale 1ns/1ps
module smd_speed_detect_tb_top;
  localparam int REF = 2_000_000;
  localparam int TMO = REF / 4000 + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fclk = 1'b0;
  logic        auto_off = 1'b0;
  logic [1:0]  mc = 2'd0;
  logic [10:0] ratio = 11'd256;
  logic        div2 = 1'b0;
  logic        dreq = 1'b1;
  logic [1:0]  mode;
  logic        mode_ok, ratio_ok, deemph_on;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  smd_speed_detect #(.REF_HZ(REF)) dut_i (
    .clk(clk), .rst_n(rst_n), .fclk_i(fclk), .auto_off_i(auto_off),
    .mc_i(mc), .ratio_i(ratio), .div2_i(div2), .deemph_req_i(dreq),
    .mode_o(mode), .mode_ok_o(mode_ok), .ratio_ok_o(ratio_ok),
    .deemph_on_o(deemph_on)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Rate REF/p tested by cross-multiplication against each band.
  function automatic int exp_class(input int p);
    longint lp = p;
    if (lp * 4000 <= REF && REF <= lp * 50000)        return 0;
    else if (lp * 84000 <= REF && REF <= lp * 100000) return 1;
    else if (lp * 170000 <= REF && REF <= lp * 200000) return 2;
    return 3;
  endfunction

  function automatic string class_req(input int c);
    case (c)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Legal ratios as base * k/2, the top multiple needing the halving option.
  function automatic bit exp_ratio(input int m, input int r, input bit d);
    int base, kmax;
    int ks[5] = '{2, 3, 4, 6, 8};
    if (m == 3) return 1'b0;
    base = (m == 0) ? 256 : 128;
    kmax = (m == 2) ? 4 : 8;
    foreach (ks[i]) begin
      if (ks[i] <= kmax && r == base * ks[i] / 2)
        return (ks[i] == kmax) ? d : 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic emit(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      fclk = 1'b1;
      repeat (p / 2) @(negedge clk);
      fclk = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  initial begin
    int sweep[8] = '{39, 40, 41, 60, 250, 499, 500, 501};
    int rl[12] = '{64, 96, 128, 192, 256, 384, 512, 768, 1024, 100, 0, 2047};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(mode == 2'd3, "R1", mode, 3);
    check(!mode_ok, "R1", mode_ok, 0);
    check(!ratio_ok, "R1", ratio_ok, 0);
    check(!deemph_on, "R1", deemph_on, 0);

    // R2 R3 R4 R5 period sweep across all band edges
    for (int p = 8; p <= 32; p++) begin
      emit(p, 6);
      check(mode == 2'(exp_class(p)), class_req(exp_class(p)), mode, exp_class(p));
      check(mode_ok == (exp_class(p) != 3), class_req(exp_class(p)), mode_ok,
            exp_class(p) != 3);
    end
    foreach (sweep[i]) begin
      emit(sweep[i], 6);
      check(mode == 2'(exp_class(sweep[i])), class_req(exp_class(sweep[i])),
            mode, exp_class(sweep[i]));
    end

    // R6 agreement filter
    emit(100, 6);
    check(mode == 2'd0, "R6", mode, 0);
    emit(22, 2);
    emit(100, 1);
    check(mode == 2'd0, "R6", mode, 0);
    emit(100, 4);
    emit(22, 3);
    check(mode == 2'd0, "R6", mode, 0);
    emit(22, 1);
    check(mode == 2'd1, "R6", mode, 1);

    // R11 in automatic double: masked
    check(!deemph_on, "R11", deemph_on, 0);

    // R7 manual selection, R9 R10 ratio table, R11 de-emphasis mask
    auto_off = 1'b1;
    for (int m = 0; m < 4; m++) begin
      mc = 2'(m);
      @(negedge clk);
      check(mode == 2'(m), "R7", mode, m);
      check(mode_ok == (m != 3), "R7", mode_ok, m != 3);
      dreq = 1'b1;
      @(negedge clk);
      check(deemph_on == (m == 0), "R11", deemph_on, m == 0);
      dreq = 1'b0;
      @(negedge clk);
      check(!deemph_on, "R11", deemph_on, 0);
      for (int d = 0; d < 2; d++) begin
        foreach (rl[i]) begin
          div2 = d[0];
          ratio = 11'(rl[i]);
          @(negedge clk);
          check(ratio_ok == exp_ratio(m, rl[i], d[0]),
                (rl[i] == 1024 || rl[i] == 512 || rl[i] == 256) ? "R10" : "R9",
                ratio_ok, exp_ratio(m, rl[i], d[0]));
        end
      end
    end

    // R8 measurement continues under manual control
    mc = 2'd0;
    emit(11, 8);
    check(mode == 2'd0, "R7", mode, 0);
    auto_off = 1'b0;
    @(negedge clk);
    check(mode == 2'd2, "R8", mode, 2);

    // R5 stopped frame clock
    fclk = 1'b0;
    repeat (3 * TMO + 20) @(negedge clk);
    check(mode == 2'd3, "R5", mode, 3);
    check(!mode_ok, "R5", mode_ok, 0);
    dreq = 1'b1;
    ratio = 11'd128;
    @(negedge clk);
    check(!deemph_on, "R11", deemph_on, 0);
    check(!ratio_ok, "R9", ratio_ok, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule